// File: doc/BRIEF.md
# Phase-Aware RAM Column-Strobe Gate

This block sits beside the DRAM column-strobe path of a small 8-bit system. Each access cycle it looks at the 16-bit bus address, the active-low RAM-overlay input from the expansion connector and a flag that says whether the processor or the video fetcher owns the slot. From these it decides whether the RAM column strobe must be held off so that another device (the I/O page, the ROM or an expansion card) can drive the data bus. It also reports when that decision leaves the bus with no driver at all, so that a bus-snooping monitor knows which bytes to discard.

By default the ownership flag is merged ahead of the address and overlay decode. The ROM and I/O checks therefore fire in the video slot too. A video fetch that walks past the top of video memory into ROM space has its RAM output cancelled, and because no device answers a video fetch, the bus floats. A parameter selects the corrected variant, which applies the decode only in the processor slot. Both outputs are registered on the access-clock edge and change together.

Top module: `cas_phase_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `cas_block` and `bus_undriven` are 0 after that edge.
- R2: An address from 0x0300 through 0x03FF (the I/O page) gives `cas_block` = 1. The neighbours 0x02FF and 0x0400 give 0 in either slot when `map_n` = 1.
- R3: An address at or above 0xC000 with `map_n` = 1 (overlay not requested) gives `cas_block` = 1. Address 0xBFFF gives 0.
- R4: `map_n` is active low. With `map_n` = 0, an address at or above 0xC000 gives `cas_block` = 0 in either slot, because RAM replaces the ROM there.
- R5: Any other address (below 0x0300, or 0x0400 through 0xBFFF) gives `cas_block` = 0.
- R6: With `PHASE_MERGED` = 1 (default), R2 to R4 apply identically when `vid_slot` = 1 (video owns the slot) and when `vid_slot` = 0 (processor owns it).
- R7: `bus_undriven` = 1 exactly when `cas_block` = 1 and the access was in the video slot. In the processor slot it is always 0, because the selected device drives the bus.
- R8: Both outputs reflect the inputs sampled at the previous rising clock edge. They update together and follow a new input value on every cycle.
- R9: With `PHASE_MERGED` = 0, a video-slot access never gives `cas_block` or `bus_undriven` = 1. Processor-slot results match R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access-slot clock; outputs update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus address of the current slot |
| map_n | input | 1 | Active-low RAM overlay request for ROM space |
| vid_slot | input | 1 | 1 = video fetcher owns the slot, 0 = processor |
| cas_block | output | 1 | 1 = hold off the RAM column strobe |
| bus_undriven | output | 1 | 1 = nobody drives the data bus this slot |

## Verification
The assertions check on every cycle the rules that tie one slot's inputs to the next cycle's outputs. These are: the I/O page and unmapped ROM space are blocked, the overlay opens ROM space, low RAM stays open, a floating bus always means a blocked strobe in a video slot, and the corrected variant never blocks video. Only the bench scenarios show the exact boundary addresses and the walk of video fetches across 0xC000 that turns clean reads into floating ones. They also show that the merged and corrected variants differ only in the video slot, and that reset clears the outputs even while a blocking address is applied.

// File: rtl/cas_gate_pkg.sv
// Package: shared types for the column-strobe gate.
// Assumes a flat address space split into RAM, one I/O page and ROM at the top.
package cas_gate_pkg;

    // Address class produced by the region decoder.
    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_IO  = 2'd1,
        RGN_ROM = 2'd2
    } region_e;

    // Gate decision carried through the output register.
    typedef struct packed {
        logic block;
        logic undriven;
    } gate_s;

endpackage

// File: rtl/cas_region_dec.sv
// Module: cas_region_dec
// Classifies a bus address as RAM, I/O page or ROM space.
// Assumes IO_BASE <= IO_LAST < ROM_BASE; ROM runs to the top of the space.
module cas_region_dec
    import cas_gate_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'h0300,
    parameter logic [ADDR_W-1:0] IO_LAST  = 16'h03FF,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    logic in_io;
    logic in_rom;

    // Range compares for the two special windows.
    always_comb begin
        in_io  = (addr >= IO_BASE) && (addr <= IO_LAST);
        in_rom = (addr >= ROM_BASE);
    end

    // Priority: I/O page, then ROM, else RAM.
    always_comb begin
        if (in_io)       region = RGN_IO;
        else if (in_rom) region = RGN_ROM;
        else             region = RGN_RAM;
    end

endmodule

// File: rtl/cas_gate_policy.sv
// Module: cas_gate_policy
// Turns address class, overlay request and slot owner into a gate decision.
// PHASE_MERGED=1: the owner flag is folded in ahead of the decode, so the
// decode applies in both slots. PHASE_MERGED=0: the decode is gated to the
// processor slot only. A video slot has no responding device, so a block there
// leaves the bus floating.
module cas_gate_policy
    import cas_gate_pkg::*;
#(
    parameter bit PHASE_MERGED = 1'b1
) (
    input  region_e region,
    input  logic    map_n,
    input  logic    vid_slot,
    output gate_s   gate
);

    logic decode_hit;
    logic decode_en;

    // Device collision decode: I/O page always, ROM unless overlay requested.
    always_comb begin
        decode_hit = (region == RGN_IO) || ((region == RGN_ROM) && map_n);
    end

    // Select where the slot owner enters the decode.
    generate
        if (PHASE_MERGED) begin : g_merged
            // Owner is merged before the decode: both slots see the checks.
            always_comb decode_en = 1'b1;
        end else begin : g_cpu_only
            // Corrected variant: checks only in the processor slot.
            always_comb decode_en = ~vid_slot;
        end
    endgenerate

    // Final decision and floating-bus flag.
    always_comb begin
        gate.block    = decode_en && decode_hit;
        gate.undriven = gate.block && vid_slot;
    end

endmodule

// File: rtl/cas_gate_reg.sv
// Module: cas_gate_reg
// Registers the gate decision on the slot clock with synchronous active-low reset.
// Assumes a single clock domain shared with the address bus.
module cas_gate_reg
    import cas_gate_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  gate_s d,
    output gate_s q
);

    // Capture the decision; clear both flags in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: a floating bus can only come with a blocked strobe.
    p_undriven_needs_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.undriven |-> q.block);

endmodule

// File: rtl/cas_phase_gate.sv
// Module: cas_phase_gate (top)
// Decides, each access slot, whether the RAM column strobe is held off and
// whether the data bus is left without a driver. Outputs are registered.
// Assumes addr, map_n and vid_slot are stable around the rising edge.
module cas_phase_gate
    import cas_gate_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] IO_BASE      = 16'h0300,
    parameter logic [ADDR_W-1:0] IO_LAST      = 16'h03FF,
    parameter logic [ADDR_W-1:0] ROM_BASE     = 16'hC000,
    parameter bit              PHASE_MERGED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_n,
    input  logic              vid_slot,
    output logic              cas_block,
    output logic              bus_undriven
);

    region_e region;
    gate_s   gate_d;
    gate_s   gate_q;

    cas_region_dec #(
        .ADDR_W   (ADDR_W),
        .IO_BASE  (IO_BASE),
        .IO_LAST  (IO_LAST),
        .ROM_BASE (ROM_BASE)
    ) dec_i (
        .addr   (addr),
        .region (region)
    );

    cas_gate_policy #(
        .PHASE_MERGED (PHASE_MERGED)
    ) pol_i (
        .region   (region),
        .map_n    (map_n),
        .vid_slot (vid_slot),
        .gate     (gate_d)
    );

    cas_gate_reg reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_d),
        .q     (gate_q)
    );

    // Drive the ports from the registered decision.
    always_comb begin
        cas_block    = gate_q.block;
        bus_undriven = gate_q.undriven;
    end

    // R1: reset clears both outputs.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!cas_block && !bus_undriven));

    // R7: processor slot never floats.
    p_cpu_slot_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vid_slot)) |-> !bus_undriven);

    // R2: I/O page blocks (in every slot the variant decodes).
    p_io_page_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr >= IO_BASE && addr <= IO_LAST)
         && (PHASE_MERGED || !$past(vid_slot))) |-> cas_block);

    // R3: unmapped ROM space blocks in the processor slot.
    p_rom_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr >= ROM_BASE && map_n && !vid_slot)) |-> cas_block);

    // R4: overlay request opens ROM space to RAM.
    p_overlay_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr >= ROM_BASE && !map_n)) |-> !cas_block);

    // R5: low RAM below the I/O page stays open.
    p_low_ram_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr < IO_BASE)) |-> !cas_block);

    generate
        if (PHASE_MERGED) begin : g_chk_merged
            // R6: video fetch into unmapped ROM is blocked and floats.
            p_video_rom_floats_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(vid_slot && addr >= ROM_BASE && map_n))
                |-> (cas_block && bus_undriven));
        end else begin : g_chk_fixed
            // R9: corrected variant leaves video slots alone.
            p_fixed_video_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(vid_slot)) |-> (!cas_block && !bus_undriven));
        end
    endgenerate

endmodule

// File: tb/cas_phase_gate_tb_top.sv
// Bench: scoreboard. The driver task applies a slot and queues the expected
// outputs for both variants; the monitor pops one item after every edge.
module cas_phase_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        map_n = 1'b1;
    logic        vid_slot = 1'b0;
    logic        blk_m, flt_m, blk_f, flt_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  blk_m;
        logic  flt_m;
        logic  blk_f;
        logic  flt_f;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    cas_phase_gate dut_i (
        .clk (clk), .rst_n (rst_n), .addr (addr), .map_n (map_n),
        .vid_slot (vid_slot), .cas_block (blk_m), .bus_undriven (flt_m)
    );

    cas_phase_gate #(.PHASE_MERGED(1'b0)) fix_i (
        .clk (clk), .rst_n (rst_n), .addr (addr), .map_n (map_n),
        .vid_slot (vid_slot), .cas_block (blk_f), .bus_undriven (flt_f)
    );

    // Reference from the requirements: collision = I/O page, or ROM without overlay.
    function automatic logic hit(input logic [15:0] a, input logic mn);
        return (a >= 16'h0300 && a <= 16'h03FF) || (a >= 16'hC000 && mn);
    endfunction

    // Driver: apply one slot at the falling edge and queue its expectations.
    task automatic drive(input logic [15:0] a, input logic mn, input logic v, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; map_n = mn; vid_slot = v;
        e.blk_m = hit(a, mn);
        e.flt_m = hit(a, mn) && v;
        e.blk_f = hit(a, mn) && !v;
        e.flt_f = 1'b0;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: one rising edge after a slot is applied, compare all outputs.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (blk_m !== e.blk_m || flt_m !== e.flt_m || blk_f !== e.blk_f || flt_f !== e.flt_f) begin
                errors++;
                $display("FAIL %s addr=%h map_n=%b vid=%b actual m=%b%b f=%b%b expected m=%b%b f=%b%b",
                         e.tag, $past(addr), $past(map_n), $past(vid_slot),
                         blk_m, flt_m, blk_f, flt_f, e.blk_m, e.flt_m, e.blk_f, e.flt_f);
            end
        end
    end

    task automatic check_idle(input string tag);
        checks++;
        if (blk_m !== 1'b0 || flt_m !== 1'b0 || blk_f !== 1'b0 || flt_f !== 1'b0) begin
            errors++;
            $display("FAIL %s actual m=%b%b f=%b%b expected m=00 f=00", tag, blk_m, flt_m, blk_f, flt_f);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with a blocking address applied in the video slot.
        addr = 16'hC000; map_n = 1'b1; vid_slot = 1'b1;
        repeat (3) @(posedge clk);
        #1 check_idle("R1 reset");
        @(negedge clk) rst_n = 1'b1;

        // R5: plain RAM addresses.
        drive(16'h0000, 1'b1, 1'b0, "R5 zero");
        drive(16'h1234, 1'b1, 1'b0, "R5 mid");
        drive(16'hBFFF, 1'b1, 1'b0, "R5/R3 below rom");
        // R2: I/O page and its neighbours.
        drive(16'h0300, 1'b1, 1'b0, "R2 io first");
        drive(16'h0380, 1'b1, 1'b0, "R2 io mid");
        drive(16'h03FF, 1'b1, 1'b0, "R2 io last");
        drive(16'h02FF, 1'b1, 1'b0, "R2 below io");
        drive(16'h0400, 1'b1, 1'b0, "R2 above io");
        drive(16'h0400, 1'b1, 1'b1, "R2 above io video");
        // R3: ROM space without overlay.
        drive(16'hC000, 1'b1, 1'b0, "R3 rom base");
        drive(16'hFFFF, 1'b1, 1'b0, "R3 rom top");
        // R4: overlay in ROM space, both slots.
        drive(16'hC000, 1'b0, 1'b0, "R4 overlay cpu");
        drive(16'hFFFF, 1'b0, 1'b1, "R4 overlay video");
        drive(16'h0310, 1'b0, 1'b0, "R4 overlay no effect on io");
        // R6/R7/R9: video slot.
        drive(16'hC000, 1'b1, 1'b1, "R6 R7 R9 video rom");
        drive(16'h0310, 1'b1, 1'b1, "R6 R7 R9 video io");
        drive(16'hBFE0, 1'b1, 1'b1, "R7 video ram");
        // R8: back-to-back alternation, one new result each cycle.
        for (int i = 0; i < 6; i++)
            drive((i % 2) ? 16'hC008 : 16'h2000, 1'b1, 1'(i % 3 == 0), "R8 alternate");
        // R6/R7: video fetcher walking across the top of video memory.
        for (int a = 16'hBFF8; a <= 16'hC007; a++)
            drive(16'(a), 1'b1, 1'b1, "R6 R7 video walk");
        // R9: same walk in the processor slot for the corrected variant.
        for (int a = 16'hBFFE; a <= 16'hC001; a++)
            drive(16'(a), 1'b1, 1'b0, "R9 cpu walk");

        // Drain the scoreboard.
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);

        // R1: reset mid-stream clears a blocked, floating state.
        addr = 16'hC000; map_n = 1'b1; vid_slot = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk) #1 check_idle("R1 reset mid-stream");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule